// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block holds the static configuration of a storage-interface PHY and reports two completion flags back from it. Seven 32-bit control words and one read-only status word sit on a plain memory-mapped port with a byte address, a write strobe and a read strobe. Only the low half of each control word holds state. The high half of every written word is a per-bit write mask, so a single field can be changed in one bus cycle with no read-modify-write and no risk of disturbing neighbouring fields.

The bank decodes the power-up control, DLL enable, drive strength, DLL frequency band and output tap delay fields onto dedicated outputs. Software brings the PHY up by first keeping power and DLL low, then setting power, checking the calibration flag, programming the band and enabling the DLL, each step a masked write. Read data is registered: a read strobe sampled at a clock edge loads the read data output at that edge, and the value holds until the next read.

Top module: `phy_ctl_regbank`

## Requirements
- R1: A synchronous active-high reset clears every stored bit, so after reset all decoded outputs are 0 (PHY powered down, DLL off) and every control word reads 0.
- R2: On a write, data bit x (0..15) is stored only when bit x+16 of the same word is 1; every bit whose mask bit is 0 keeps its old value.
- R3: Control words live at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, each independent; a read returns the stored 16 bits in bits 15:0 and zero in bits 31:16.
- R4: In the word at 0x18, bit 0 drives `pwr_on_o` (1 = powered on), bit 1 drives `dll_en_o`, and bits 6:4 drive `drv_imp_o` (code 0=50, 1=33, 2=66, 3=100, 4=40 ohm).
- R5: In the word at 0x00, bits 13:12 drive `dll_band_o` (code 0=200, 1=50, 2=100, 3=150 MHz), bit 11 drives `otap_en_o`, and bits 10:7 drive `otap_sel_o`.
- R6: A read of offset 0x20 returns `cal_done_i` in bit 6 and `dll_ready_i` in bit 5, as sampled at the read edge, with all other bits zero.
- R7: Writes to offset 0x20, to any offset not listed in R3, and to any address with bits 1:0 nonzero change no stored bit.
- R8: Reads of offsets not listed in R3 or R6, including unaligned addresses, return zero.
- R9: `bus_rdata` changes only at an edge where `bus_rd` is sampled high; a read and write of the same word in one cycle return the value from before the write.
- R10: A write whose mask half is all zero changes nothing, whatever its data half holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write word: mask in 31:16, data in 15:0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | PHY calibration complete |
| dll_ready_i | input | 1 | PHY DLL locked |
| pwr_on_o | output | 1 | PHY power control, 1 = on |
| dll_en_o | output | 1 | DLL enable |
| drv_imp_o | output | 3 | Drive impedance code |
| dll_band_o | output | 2 | DLL frequency band code |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |

## Verification
A wrong stored bit shows up on the decoded outputs one edge after the faulty write and on `bus_rdata` one edge after the next read of that word, so a mask or decode fault is visible within two cycles of the write. A write leaking into the wrong word or through a cleared mask bit is caught by reading back every word after each ignored or partial write and comparing against a model built from the mask rule. A stale or misrouted status bit appears on the first read of 0x20 after the inputs change.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;

    // Number of control words and the stored width of each
    localparam int NUM_CTRL  = 7;
    localparam int STORE_W   = 16;

    // Byte offset of the status word
    localparam int STATUS_OFS = 32'h20;

    // Word indices that carry decoded fields
    localparam int IDX_TIMING = 0;
    localparam int IDX_POWER  = 6;

    // Field positions inside the power word
    localparam int PWR_BIT    = 0;
    localparam int DLLEN_BIT  = 1;
    localparam int IMP_LSB    = 4;
    localparam int IMP_W      = 3;

    // Field positions inside the timing word
    localparam int OTSEL_LSB  = 7;
    localparam int OTSEL_W    = 4;
    localparam int OTEN_BIT   = 11;
    localparam int BAND_LSB   = 12;
    localparam int BAND_W     = 2;

    // Field positions inside the status word
    localparam int CAL_BIT    = 6;
    localparam int LOCK_BIT   = 5;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_CTRL   = 2'd1,
        HIT_STATUS = 2'd2
    } hit_kind_t;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int N_WORDS = NUM_CTRL,
    localparam int IDX_W = $clog2(N_WORDS),
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_kind_t         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [WORD_W-1:0] LIMIT_WORD  = WORD_W'(N_WORDS);
    localparam logic [WORD_W-1:0] STATUS_WORD = WORD_W'(STATUS_OFS / 4);

    logic [WORD_W-1:0] word;
    logic              aligned;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        idx     = word[IDX_W-1:0];
        kind    = HIT_NONE;
        if (aligned) begin
            unique case (1'b1)
                (word < LIMIT_WORD):   kind = HIT_CTRL;
                (word == STATUS_WORD): kind = HIT_STATUS;
                default:               kind = HIT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/masked_field_reg.sv
module masked_field_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    always_comb begin
        q_next = q;
        if (we) begin
            q_next = (q & ~mask) | (data & mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
    import phy_regbank_pkg::*;
#(
    parameter int N_WORDS = NUM_CTRL,
    parameter int W = STORE_W,
    localparam int IDX_W = $clog2(N_WORDS)
) (
    input  hit_kind_t        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     words [N_WORDS],
    input  logic             cal_done,
    input  logic             dll_ready,
    output logic [W-1:0]     value
);

    logic [W-1:0] ctrl_val;
    logic [W-1:0] stat_val;

    always_comb begin
        ctrl_val = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (idx == IDX_W'(i)) begin
                ctrl_val = words[i];
            end
        end
    end

    always_comb begin
        stat_val           = '0;
        stat_val[CAL_BIT]  = cal_done;
        stat_val[LOCK_BIT] = dll_ready;
    end

    always_comb begin
        unique case (kind)
            HIT_CTRL:   value = ctrl_val;
            HIT_STATUS: value = stat_val;
            default:    value = '0;
        endcase
    end

endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int IDX_W = $clog2(NUM_CTRL)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 cal_done_i,
    input  logic                 dll_ready_i,
    output logic                 pwr_on_o,
    output logic                 dll_en_o,
    output logic [IMP_W-1:0]     drv_imp_o,
    output logic [BAND_W-1:0]    dll_band_o,
    output logic                 otap_en_o,
    output logic [OTSEL_W-1:0]   otap_sel_o
);

    hit_kind_t         kind;
    logic [IDX_W-1:0]  idx;
    logic [HALF_W-1:0] wr_data;
    logic [HALF_W-1:0] wr_mask;
    logic [HALF_W-1:0] ctrl_q [NUM_CTRL];
    logic [HALF_W-1:0] rd_value;

    assign wr_data = bus_wdata[HALF_W-1:0];
    assign wr_mask = bus_wdata[DATA_W-1:HALF_W];

    regbank_decode #(
        .ADDR_W  (ADDR_W),
        .N_WORDS (NUM_CTRL)
    ) decode_i (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
        logic sel;
        assign sel = bus_wr && (kind == HIT_CTRL) && (idx == IDX_W'(g));
        masked_field_reg #(
            .W (HALF_W)
        ) word_i (
            .clk  (clk),
            .rst  (rst),
            .we   (sel),
            .data (wr_data),
            .mask (wr_mask),
            .q    (ctrl_q[g])
        );
    end

    regbank_rdmux #(
        .N_WORDS (NUM_CTRL),
        .W       (HALF_W)
    ) rdmux_i (
        .kind      (kind),
        .idx       (idx),
        .words     (ctrl_q),
        .cal_done  (cal_done_i),
        .dll_ready (dll_ready_i),
        .value     (rd_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= {{(DATA_W-HALF_W){1'b0}}, rd_value};
        end
    end

    assign pwr_on_o   = ctrl_q[IDX_POWER][PWR_BIT];
    assign dll_en_o   = ctrl_q[IDX_POWER][DLLEN_BIT];
    assign drv_imp_o  = ctrl_q[IDX_POWER][IMP_LSB +: IMP_W];
    assign dll_band_o = ctrl_q[IDX_TIMING][BAND_LSB +: BAND_W];
    assign otap_en_o  = ctrl_q[IDX_TIMING][OTEN_BIT];
    assign otap_sel_o = ctrl_q[IDX_TIMING][OTSEL_LSB +: OTSEL_W];

endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cal_done_i,
    input logic              dll_ready_i,
    input logic              pwr_on_o,
    input logic              dll_en_o,
    input logic [2:0]        drv_imp_o,
    input logic [1:0]        dll_band_o,
    input logic              otap_en_o,
    input logic [3:0]        otap_sel_o
);

    localparam logic [ADDR_W-1:0] A_POWER  = ADDR_W'(24);
    localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(32);

    logic [11:0] outs;
    assign outs = {pwr_on_o, dll_en_o, drv_imp_o, dll_band_o, otap_en_o, otap_sel_o};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (outs == 12'd0 && bus_rdata == '0));

    assert_masked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_POWER && !bus_wdata[16]) |-> (pwr_on_o == $past(pwr_on_o)));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:DATA_W/2] == '0);

    assert_power_field_R4: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_POWER && bus_wdata[16]) |-> (pwr_on_o == $past(bus_wdata[0])));

    assert_otap_field_R5: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_TIMING && bus_wdata[27]) |-> (otap_en_o == $past(bus_wdata[11])));

    assert_status_read_R6: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && bus_addr == A_STATUS) |->
            (bus_rdata[6] == $past(cal_done_i) && bus_rdata[5] == $past(dll_ready_i)));

    assert_status_ro_R7: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_STATUS) |-> $stable(outs));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (.*);

// File: tb/phy_ctl_regbank_tb_top.sv
module phy_ctl_regbank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cal_done_i = 1'b0;
    logic        dll_ready_i = 1'b0;
    logic        pwr_on_o;
    logic        dll_en_o;
    logic [2:0]  drv_imp_o;
    logic [1:0]  dll_band_o;
    logic        otap_en_o;
    logic [3:0]  otap_sel_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [7];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctl_regbank dut_i (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .cal_done_i (cal_done_i), .dll_ready_i (dll_ready_i),
        .pwr_on_o (pwr_on_o), .dll_en_o (dll_en_o), .drv_imp_o (drv_imp_o),
        .dll_band_o (dll_band_o), .otap_en_o (otap_en_o), .otap_sel_o (otap_sel_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard one half cycle after each read edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected read result", bus_rdata, 32'hxxxx_xxxx);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr_raw(input logic [5:0] a, input logic [15:0] m, input logic [15:0] d);
        bus_addr = a; bus_wdata = {m, d}; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input int idx, input logic [15:0] m, input logic [15:0] d);
        model[idx] = (model[idx] & ~m) | (d & m);
        wr_raw(6'(idx * 4), m, d);
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 7; i++) rd(6'(i * 4), {16'h0, model[i]}, tag);
        @(negedge clk);
    endtask

    task automatic check_outs(input string tag);
        check({tag, " pwr"},  {31'd0, pwr_on_o},   {31'd0, model[6][0]});
        check({tag, " dll"},  {31'd0, dll_en_o},   {31'd0, model[6][1]});
        check({tag, " imp"},  {29'd0, drv_imp_o},  {29'd0, model[6][6:4]});
        check({tag, " band"}, {30'd0, dll_band_o}, {30'd0, model[0][13:12]});
        check({tag, " oten"}, {31'd0, otap_en_o},  {31'd0, model[0][11]});
        check({tag, " osel"}, {28'd0, otap_sel_o}, {28'd0, model[0][10:7]});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 7; i++) model[i] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check_outs("R1 after reset");
        rd_all("R1 R3 reset readback");

        // R4 power field, single bit under mask
        wr_ctrl(6, 16'h0001, 16'hFFFF);
        check_outs("R4 power on only");
        wr_ctrl(6, 16'h0070, 16'h0042);
        check_outs("R4 impedance 40 ohm code");
        wr_ctrl(6, 16'h0002, 16'h0002);
        check_outs("R4 dll enable");

        // R5 timing fields: band 3, tap enable, tap 4
        wr_ctrl(0, 16'h3F80, 16'h3A00);
        check_outs("R5 timing fields");
        wr_ctrl(0, 16'h3000, 16'h1000);
        check_outs("R5 band change keeps tap");

        // R2 / R3 partial masks on every word
        for (int i = 0; i < 7; i++) wr_ctrl(i, 16'hA5C3 ^ 16'(i * 16'h1111), 16'h5A3C + 16'(i));
        for (int i = 0; i < 7; i++) wr_ctrl(i, 16'h0FF0, 16'hFFFF - 16'(i));
        rd_all("R2 R3 masked readback");
        check_outs("R2 masked outputs");

        // R10 zero mask
        for (int i = 0; i < 7; i++) wr_ctrl(i, 16'h0000, 16'hFFFF);
        rd_all("R10 zero mask readback");
        check_outs("R10 zero mask outputs");

        // R7 ignored writes
        wr_raw(6'h20, 16'hFFFF, 16'hFFFF);
        wr_raw(6'h1C, 16'hFFFF, 16'h0000);
        wr_raw(6'h24, 16'hFFFF, 16'h1234);
        wr_raw(6'h3C, 16'hFFFF, 16'hFFFF);
        wr_raw(6'h19, 16'hFFFF, 16'h0000);
        wr_raw(6'h01, 16'hFFFF, 16'hFFFF);
        rd_all("R7 ignored writes readback");
        check_outs("R7 ignored writes outputs");

        // R8 unmapped reads
        rd(6'h1C, 32'h0, "R8 read 0x1C");
        rd(6'h24, 32'h0, "R8 read 0x24");
        rd(6'h3C, 32'h0, "R8 read 0x3C");
        rd(6'h02, 32'h0, "R8 read unaligned");
        @(negedge clk);

        // R6 status bits
        cal_done_i = 1'b1; dll_ready_i = 1'b0;
        rd(6'h20, 32'h0000_0040, "R6 cal only");
        cal_done_i = 1'b0; dll_ready_i = 1'b1;
        rd(6'h20, 32'h0000_0020, "R6 lock only");
        cal_done_i = 1'b1; dll_ready_i = 1'b1;
        rd(6'h20, 32'h0000_0060, "R6 both");
        cal_done_i = 1'b0; dll_ready_i = 1'b0;
        rd(6'h20, 32'h0000_0000, "R6 none");
        @(negedge clk);

        // R9 same-cycle read and write returns old value
        bus_addr = 6'h04; bus_wdata = {16'hFFFF, 16'hBEEF};
        bus_wr = 1'b1; bus_rd = 1'b1;
        exp_q.push_back({16'h0, model[1]}); tag_q.push_back("R9 read during write");
        model[1] = 16'hBEEF;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        rd(6'h04, 32'h0000_BEEF, "R9 read after write");
        @(negedge clk);
        // R9 hold without a read strobe
        cal_done_i = 1'b1;
        wr_ctrl(2, 16'hFFFF, 16'h0F0F);
        repeat (3) @(negedge clk);
        check("R9 rdata holds", bus_rdata, 32'h0000_BEEF);
        cal_done_i = 1'b0;

        // R1 reset mid-run
        do_reset();
        check_outs("R1 second reset");
        rd_all("R1 second reset readback");

        check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule